// File: doc/BRIEF.md
# Prescaled Free-Running Interval Timer

This block is an 8-bit up-counter that always runs. A prescaler divides its input by a selectable power of two, and each prescaler tick advances the counter. The input to the prescaler is one of two clock-enable pulse streams, both in the single system clock domain. One stream stands for the main oscillator and the other for an internal RC oscillator. The prescaler tick is also brought out as a time base for a downstream watchdog. When the count wraps from FFh to 00h, the block raises an interrupt request flag, and the flag stays set until it is acknowledged.

Software sees one location. A read returns the live count. A write goes to the control register, which holds four fields: a 3-bit divide select in bits [2:0], a counter-clear bit in bit 3 that clears itself, a source select in bit 4, and a watchdog-enable bit in bit 5. The watchdog-enable bit is passed straight out to the watchdog logic, where it chooses between watchdog operation and a plain timer function.

Top module: `itv_top`

## Requirements
- R1: The 8-bit count rises by exactly one on each prescaler tick and holds when there is no tick. It wraps from FFh to 00h, and no control setting stops it.
- R2: When the divide-select field wr_data[2:0] holds value s, a tick occurs on every 2^(s+3)-th selected source pulse, counted from the last clear. So 000 divides by 8 and 111 divides by 1024.
- R3: A wrap from FFh to 00h sets irq_flag in the same clock edge as the wrap. irq_flag stays set until a cycle with irq_ack high and no wrap clears it. If a wrap and irq_ack fall in the same cycle, the flag stays set.
- R4: A write with bit 3 set makes the clear bit high for the one cycle after the write. At the end of that cycle the count and the prescaler are zero and the clear bit has dropped by itself. Counting then resumes from zero.
- R5: Bit 4 selects the source. With 0, only main_ce pulses reach the prescaler. With 1, only rc_ce pulses reach it, and pulses on the other input have no effect.
- R6: rd_data always equals the count. A write with bit 3 clear leaves the count unchanged.
- R7: wdt_tick is high for exactly the system cycles in which the count advances, one pulse per increment.
- R8: Bit 5 of the last write appears on wdt_en from the cycle after that write.
- R9: After reset, the count, the prescaler, all control fields and irq_flag are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| main_ce | input | 1 | Main oscillator pulse, one system cycle wide |
| rc_ce | input | 1 | Internal RC oscillator pulse, one system cycle wide |
| wr_en | input | 1 | Write strobe for the shared location |
| wr_data | input | 8 | Control value: [2:0] divide select, [3] clear, [4] source, [5] watchdog enable |
| rd_data | output | 8 | Current count |
| irq_ack | input | 1 | Clears the interrupt flag |
| irq_flag | output | 1 | Interrupt request, set on counter wrap |
| wdt_tick | output | 1 | Prescaled tick for the watchdog |
| wdt_en | output | 1 | Watchdog-enable control bit |

## Verification
- A source pulse presented in a cycle shows up in rd_data, and in irq_flag for a wrap, after that cycle's rising edge.
- wdt_tick is combinational, so it is high in the same cycle as the pulse that causes the increment.
- A write takes two edges to take full effect: the first loads the control register, and the second applies the clear.
- The bench drives every input on the falling edge and reads results on a later falling edge. Each write task waits out both edges before any count is checked, so every sample lands after the edge that produces it.

// File: rtl/itv_pkg.sv
package itv_pkg;
    localparam int CNT_W     = 8;
    localparam int PRE_W     = 10;
    localparam int SEL_W     = 3;
    localparam int MIN_SHIFT = 3;
    localparam int DATA_W    = 8;

    localparam int CLR_BIT = 3;
    localparam int SRC_BIT = 4;
    localparam int WDE_BIT = 5;

    typedef struct packed {
        logic             wdt_en;
        logic             src_rc;
        logic             clr;
        logic [SEL_W-1:0] div_sel;
    } ctrl_t;

    // Mask of prescaler bits that must all be ones for a tick at select s.
    function automatic logic [PRE_W-1:0] tick_mask(input logic [SEL_W-1:0] s);
        logic [PRE_W-1:0] m;
        m = '0;
        for (int i = 0; i < PRE_W; i++) begin
            if (i < int'(s) + MIN_SHIFT) m[i] = 1'b1;
        end
        return m;
    endfunction
endpackage

// File: rtl/itv_ctrl_reg.sv
module itv_ctrl_reg
    import itv_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output ctrl_t             ctrl
);
    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl <= '0;
        end else if (wr_en) begin
            ctrl.div_sel <= wr_data[SEL_W-1:0];
            ctrl.clr     <= wr_data[CLR_BIT];
            ctrl.src_rc  <= wr_data[SRC_BIT];
            ctrl.wdt_en  <= wr_data[WDE_BIT];
        end else begin
            ctrl.clr <= 1'b0;
        end
    end
endmodule

// File: rtl/itv_prescaler.sv
module itv_prescaler
    import itv_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             main_ce,
    input  logic             rc_ce,
    input  logic             src_rc,
    input  logic [SEL_W-1:0] div_sel,
    input  logic             clr,
    output logic             tick
);
    logic             src_ce;
    logic [PRE_W-1:0] pre;
    logic [PRE_W-1:0] mask;

    assign src_ce = src_rc ? rc_ce : main_ce;
    assign mask   = tick_mask(div_sel);
    assign tick   = src_ce && !clr && ((pre & mask) == mask);

    always_ff @(posedge clk) begin
        if (rst || clr)  pre <= '0;
        else if (src_ce) pre <= pre + PRE_W'(1);
    end
endmodule

// File: rtl/itv_counter.sv
module itv_counter
    import itv_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             tick,
    input  logic             irq_ack,
    output logic [CNT_W-1:0] count,
    output logic             irq_flag
);
    logic wrap;
    assign wrap = tick && (&count);

    always_ff @(posedge clk) begin
        if (rst || clr) count <= '0;
        else if (tick)  count <= count + CNT_W'(1);
    end

    always_ff @(posedge clk) begin
        if (rst)          irq_flag <= 1'b0;
        else if (wrap)    irq_flag <= 1'b1;
        else if (irq_ack) irq_flag <= 1'b0;
    end
endmodule

// File: rtl/itv_top.sv
module itv_top
    import itv_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              main_ce,
    input  logic              rc_ce,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    input  logic              irq_ack,
    output logic              irq_flag,
    output logic              wdt_tick,
    output logic              wdt_en
);
    ctrl_t            ctrl;
    logic             tick;
    logic [CNT_W-1:0] count;

    itv_ctrl_reg u_ctrl (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .ctrl(ctrl)
    );

    itv_prescaler u_pre (
        .clk(clk), .rst(rst), .main_ce(main_ce), .rc_ce(rc_ce),
        .src_rc(ctrl.src_rc), .div_sel(ctrl.div_sel), .clr(ctrl.clr), .tick(tick)
    );

    itv_counter u_cnt (
        .clk(clk), .rst(rst), .clr(ctrl.clr), .tick(tick), .irq_ack(irq_ack),
        .count(count), .irq_flag(irq_flag)
    );

    assign rd_data  = DATA_W'(count);
    assign wdt_tick = tick;
    assign wdt_en   = ctrl.wdt_en;
endmodule

// File: rtl/itv_checker.sv
module itv_checker (
    input logic       clk,
    input logic       rst,
    input logic       clr,
    input logic       tick,
    input logic [7:0] count,
    input logic       irq_flag,
    input logic       irq_ack,
    input logic       wr_en,
    input logic [7:0] wr_data,
    input logic       wdt_en
);
    p_step_r1: assert property (@(posedge clk) disable iff (rst)
        (tick && !clr) |=> count == $past(count) + 8'd1);
    p_hold_r1: assert property (@(posedge clk) disable iff (rst)
        (!tick && !clr) |=> $stable(count));
    p_wrap_r3: assert property (@(posedge clk) disable iff (rst)
        (tick && count == 8'hFF) |=> irq_flag);
    p_ack_r3: assert property (@(posedge clk) disable iff (rst)
        (irq_ack && !(tick && count == 8'hFF)) |=> !irq_flag);
    p_clear_r4: assert property (@(posedge clk) disable iff (rst)
        clr |=> (count == 8'd0));
    p_selfclr_r4: assert property (@(posedge clk) disable iff (rst)
        (clr && !wr_en) |=> !clr);
    p_wde_r8: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (wdt_en == $past(wr_data[5])));
endmodule

bind itv_top itv_checker u_chk (
    .clk(clk), .rst(rst), .clr(ctrl.clr), .tick(tick), .count(count),
    .irq_flag(irq_flag), .irq_ack(irq_ack), .wr_en(wr_en), .wr_data(wr_data),
    .wdt_en(wdt_en)
);

// File: tb/sim_itv_top.sv
module sim_itv_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       main_ce = 1'b0, rc_ce = 1'b0, wr_en = 1'b0, irq_ack = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic       irq_flag, wdt_tick, wdt_en;
    int         checks = 0, fails = 0, ticks = 0;

    always #5 clk = ~clk;

    itv_top u0 (
        .clk(clk), .rst(rst), .main_ce(main_ce), .rc_ce(rc_ce),
        .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
        .irq_ack(irq_ack), .irq_flag(irq_flag), .wdt_tick(wdt_tick), .wdt_en(wdt_en)
    );

    always @(posedge clk) if (wdt_tick) ticks <= ticks + 1;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] d);
        @(negedge clk); wr_en = 1'b1; wr_data = d;
        @(negedge clk); wr_en = 1'b0;
        @(negedge clk);
    endtask

    task automatic pulses(input int n, input bit rc);
        if (n > 0) begin
            @(negedge clk);
            if (rc) rc_ce = 1'b1; else main_ce = 1'b1;
            repeat (n - 1) @(negedge clk);
            @(negedge clk);
            main_ce = 1'b0; rc_ce = 1'b0;
        end
    endtask

    task automatic finish_up;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual hung expected done");
        finish_up();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R9 reset state
        chk("R9 count", rd_data, 0);
        chk("R9 irq", irq_flag, 0);
        chk("R9 wdt_en", wdt_en, 0);

        // R2/R7 divide sweep over every select value
        for (int s = 0; s < 8; s++) begin
            int per;
            per = 1 << (s + 3);
            wr(8'h08 | 8'(s));
            ticks = 0;
            pulses(3 * per - 1, 1'b0);
            chk("R2 before step", rd_data, 2);
            pulses(1, 1'b0);
            chk("R2 on step", rd_data, 3);
            chk("R7 tick count", ticks, 3);
        end

        // R6 write without clear keeps count
        wr(8'h02);
        chk("R6 read equals count", rd_data, 3);

        // R4 clear zeroes and counting resumes
        wr(8'h08);
        chk("R4 cleared", rd_data, 0);
        pulses(40, 1'b0);
        chk("R4 resumes", rd_data, 5);

        // R1/R3 wrap at divide by 8
        wr(8'h08);
        pulses(2047, 1'b0);
        chk("R1 at FF", rd_data, 255);
        chk("R3 not yet", irq_flag, 0);
        pulses(1, 1'b0);
        chk("R1 wraps to 0", rd_data, 0);
        chk("R3 set on wrap", irq_flag, 1);
        pulses(7, 1'b0);
        chk("R3 sticky", irq_flag, 1);
        @(negedge clk); irq_ack = 1'b1;
        @(negedge clk); irq_ack = 1'b0;
        chk("R3 ack clears", irq_flag, 0);

        // R3 wrap and ack in the same cycle: wrap wins
        wr(8'h08);
        pulses(2047, 1'b0);
        @(negedge clk); main_ce = 1'b1; irq_ack = 1'b1;
        @(negedge clk); main_ce = 1'b0; irq_ack = 1'b0;
        chk("R3 wrap over ack", irq_flag, 1);
        chk("R1 wrap count", rd_data, 0);

        // R5 source select
        wr(8'h18);
        pulses(16, 1'b0);
        chk("R5 main ignored", rd_data, 0);
        pulses(16, 1'b1);
        chk("R5 rc counted", rd_data, 2);
        wr(8'h08);
        pulses(16, 1'b1);
        chk("R5 rc ignored", rd_data, 0);
        pulses(16, 1'b0);
        chk("R5 main counted", rd_data, 2);

        // R8 watchdog enable passthrough
        wr(8'h20);
        chk("R8 set", wdt_en, 1);
        wr(8'h00);
        chk("R8 cleared", wdt_en, 0);

        finish_up();
    end
endmodule